// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps the coherence state of a small set of lines in one private cache that sits on a shared snooping bus. Each line is Invalid (no copy), Shared (a read-only copy that other caches may also hold) or Modified (the only valid copy, writable). The processor side presents one read or write request at a time. The controller either completes it at once as a hit or raises a bus request and keeps the processor waiting until the bus grants it.

The bus side shows every transaction placed on the bus by any cache, in one global order. A snooped transaction that comes from another cache and names a tracked line can downgrade or invalidate that line. When the line is Modified, the controller also raises a one-cycle strobe that tells the data path to supply the line. Transactions carrying this controller's own requester ID are ignored. A snoop and a processor request in the same cycle are ordered snoop first. The request is then judged against the state the snoop left behind, so a pending upgrade from Shared becomes a full read-exclusive once its copy has been invalidated.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After a synchronous reset every line is Invalid. With no request and no snoop, `cpu_ready`, `bus_req_valid` and `flush_valid` are low.
- R2: A read to an Invalid line drives `bus_req_valid` with `bus_req_op` = 1 (read) and `bus_req_line` = the requested line. `cpu_ready` stays low until the cycle `bus_gnt` is high. In that cycle `cpu_ready` is high and the line becomes Shared.
- R3: A read to a Shared or Modified line sets `cpu_ready` in the same cycle, with no bus request and no change of state.
- R4: A write to an Invalid line requests `bus_req_op` = 2 (read-exclusive). A write to a Shared line requests `bus_req_op` = 3 (upgrade, read-exclusive without data). On grant the line becomes Modified.
- R5: A write to a Modified line sets `cpu_ready` in the same cycle, with no bus request.
- R6: A foreign snoop with `snp_op` = 1 (read) on a Modified line pulses `flush_valid` with `flush_line` = `snp_line` and leaves the line Shared. On a Shared or Invalid line it has no effect.
- R7: A foreign snoop with `snp_op` = 2 or 3 invalidates a Shared line without a flush. It invalidates a Modified line and pulses `flush_valid`. An Invalid line is unchanged.
- R8: A snoop whose `snp_id` equals the `MY_ID` parameter causes no flush and no state change.
- R9: When a foreign snoop and a processor request name the same line in one cycle, the snoop takes effect first. The hit decision and the requested opcode in that cycle follow the post-snoop state, so an upgrade (3) becomes read-exclusive (2).
- R10: `bus_gnt` without an own bus request has no effect, and `cpu_ready` never rises while the own request waits without grant.
- R11: A request withdrawn before its grant leaves every line unchanged. An operation on one line never alters another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_line | input | LINE_W | Line index of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req_valid | output | 1 | Own bus request pending |
| bus_req_op | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_line | output | LINE_W | Line of the own bus request |
| bus_gnt | input | 1 | Bus grants the own request this cycle |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped opcode, same coding as bus_req_op |
| snp_line | input | LINE_W | Line named by the snooped transaction |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| flush_valid | output | 1 | Supply the line's data to the bus |
| flush_line | output | LINE_W | Line to supply |

## Verification
The checks assume that the processor holds its request until `cpu_ready` or withdraws it, and that `bus_gnt` comes only in a cycle with the own request visible. They also assume that a grant cycle carries the controller's own transaction on the snoop port. The bench drives each transaction for exactly one clock edge. It grants only while a request is shown, and it echoes the own ID on the snoop port in every grant cycle. The only exceptions are deliberate stray grants, which test R10 with no request present. Cases that combine a snoop with a processor request on the same line are placed in single chosen cycles, so that the snoop-first ordering is exercised directly.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_state_t;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_RD   = 2'd1,
        BOP_RDX  = 2'd2,
        BOP_UPGR = 2'd3
    } bus_op_t;

    function automatic logic op_is_excl(bus_op_t op);
        return (op == BOP_RDX) || (op == BOP_UPGR);
    endfunction

endpackage

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
(
    input  line_state_t cur_state,
    input  logic        snoop_hit,
    input  bus_op_t     snoop_op,
    output line_state_t post_state,
    output logic        flush_req
);

    always_comb begin
        post_state = cur_state;
        flush_req  = 1'b0;
        if (snoop_hit) begin
            if (snoop_op == BOP_RD) begin
                if (cur_state == LS_MOD) begin
                    post_state = LS_SHR;
                    flush_req  = 1'b1;
                end
            end else if (op_is_excl(snoop_op)) begin
                flush_req  = (cur_state == LS_MOD);
                post_state = LS_INV;
            end
        end
    end

endmodule

// File: rtl/msi_cpu_unit.sv
module msi_cpu_unit
    import msi_pkg::*;
(
    input  logic        req_valid,
    input  logic        req_write,
    input  line_state_t cur_state,
    input  logic        gnt,
    output logic        ready,
    output logic        bus_valid,
    output bus_op_t     bus_op,
    output logic        upd,
    output line_state_t new_state
);

    always_comb begin
        ready     = 1'b0;
        bus_valid = 1'b0;
        bus_op    = BOP_NONE;
        upd       = 1'b0;
        new_state = cur_state;
        if (req_valid) begin
            if (!req_write) begin
                if (cur_state == LS_INV) begin
                    bus_valid = 1'b1;
                    bus_op    = BOP_RD;
                end else begin
                    ready = 1'b1;
                end
            end else begin
                if (cur_state == LS_MOD) begin
                    ready = 1'b1;
                end else begin
                    bus_valid = 1'b1;
                    bus_op    = (cur_state == LS_SHR) ? BOP_UPGR : BOP_RDX;
                end
            end
        end
        if (bus_valid && gnt) begin
            ready     = 1'b1;
            upd       = 1'b1;
            new_state = req_write ? LS_MOD : LS_SHR;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ID_W      = 2,
    parameter int MY_ID     = 0,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [LINE_W-1:0] cpu_req_line,
    output logic              cpu_ready,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_op,
    output logic [LINE_W-1:0] bus_req_line,
    input  logic              bus_gnt,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [LINE_W-1:0] snp_line,
    input  logic [ID_W-1:0]   snp_id,
    output logic              flush_valid,
    output logic [LINE_W-1:0] flush_line
);

    typedef struct packed {
        line_state_t [NUM_LINES-1:0] lines;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                        snp_foreign;
    line_state_t [NUM_LINES-1:0] post_st;
    logic [NUM_LINES-1:0]        flush_vec;

    logic        cpu_upd;
    line_state_t cpu_new;
    bus_op_t     cpu_op;

    assign snp_foreign = snp_valid && (snp_id != ID_W'(MY_ID));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        msi_snoop_unit u_snoop (
            .cur_state (ctl_q.lines[g]),
            .snoop_hit (snp_foreign && (snp_line == LINE_W'(g))),
            .snoop_op  (bus_op_t'(snp_op)),
            .post_state(post_st[g]),
            .flush_req (flush_vec[g])
        );
    end

    msi_cpu_unit u_cpu (
        .req_valid(cpu_req_valid),
        .req_write(cpu_req_write),
        .cur_state(post_st[cpu_req_line]),
        .gnt      (bus_gnt),
        .ready    (cpu_ready),
        .bus_valid(bus_req_valid),
        .bus_op   (cpu_op),
        .upd      (cpu_upd),
        .new_state(cpu_new)
    );

    always_comb begin
        ctl_d.lines = post_st;
        if (cpu_upd) begin
            ctl_d.lines[cpu_req_line] = cpu_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_req_op   = cpu_op;
    assign bus_req_line = cpu_req_line;
    assign flush_valid  = |flush_vec;
    assign flush_line   = snp_line;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int NUM_LINES = 4,
    parameter int ID_W      = 2,
    parameter int MY_ID     = 0,
    parameter int LINE_W    = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_req_write,
    input logic                   cpu_ready,
    input logic                   bus_req_valid,
    input logic [1:0]             bus_req_op,
    input logic [LINE_W-1:0]      bus_req_line,
    input logic                   bus_gnt,
    input logic                   snp_valid,
    input logic [1:0]             snp_op,
    input logic [LINE_W-1:0]      snp_line,
    input logic [ID_W-1:0]        snp_id,
    input logic                   flush_valid,
    input logic [2*NUM_LINES-1:0] st_vec
);

    function automatic logic [1:0] st_of(logic [2*NUM_LINES-1:0] v, logic [LINE_W-1:0] idx);
        return v[int'(idx)*2 +: 2];
    endfunction

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_inv_R1: assert (st_vec == '0);
        end
    end

    assert_wait_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_gnt |-> !cpu_ready);

    assert_rd_only_for_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_op == 2'd1 |-> !cpu_req_write);

    assert_grant_read_shr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_gnt && !cpu_req_write |=> st_of(st_vec, $past(bus_req_line)) == 2'd1);

    assert_grant_write_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_gnt && cpu_req_write |=> st_of(st_vec, $past(bus_req_line)) == 2'd2);

    assert_flush_from_mod_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> st_of(st_vec, snp_line) == 2'd2);

    assert_flush_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> snp_valid && snp_id != ID_W'(MY_ID));

    assert_excl_snoop_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_id != ID_W'(MY_ID) && snp_op[1]
        && !(bus_req_valid && bus_gnt && bus_req_line == snp_line)
        |=> st_of(st_vec, $past(snp_line)) == 2'd0);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .NUM_LINES(NUM_LINES),
    .ID_W     (ID_W),
    .MY_ID    (MY_ID),
    .LINE_W   (LINE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req_write(cpu_req_write),
    .cpu_ready    (cpu_ready),
    .bus_req_valid(bus_req_valid),
    .bus_req_op   (bus_req_op),
    .bus_req_line (bus_req_line),
    .bus_gnt      (bus_gnt),
    .snp_valid    (snp_valid),
    .snp_op       (snp_op),
    .snp_line     (snp_line),
    .snp_id       (snp_id),
    .flush_valid  (flush_valid),
    .st_vec       (ctl_q)
);

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;

    localparam int N       = 4;
    localparam int LW      = 2;
    localparam int IW      = 2;
    localparam int MY      = 1;
    localparam int FOREIGN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [LW-1:0] cpu_req_line = '0;
    logic          cpu_ready;
    logic          bus_req_valid;
    logic [1:0]    bus_req_op;
    logic [LW-1:0] bus_req_line;
    logic          bus_gnt = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = '0;
    logic [LW-1:0] snp_line = '0;
    logic [IW-1:0] snp_id = '0;
    logic          flush_valid;
    logic [LW-1:0] flush_line;

    int errors = 0;
    int checks = 0;
    int exp_st [N];
    bit done = 0;

    always #4 clk = ~clk;

    msi_snoop_ctrl #(.NUM_LINES(N), .ID_W(IW), .MY_ID(MY)) i_msi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_line(cpu_req_line), .cpu_ready(cpu_ready),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
        .bus_req_line(bus_req_line), .bus_gnt(bus_gnt),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line), .snp_id(snp_id),
        .flush_valid(flush_valid), .flush_line(flush_line)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic drive(input bit cv, input bit cw, input int cl, input bit g,
                         input bit sv, input int sop, input int sl, input int sid);
        @(negedge clk);
        cpu_req_valid = cv;
        cpu_req_write = cw;
        cpu_req_line  = LW'(cl);
        bus_gnt       = g;
        snp_valid     = sv;
        snp_op        = 2'(sop);
        snp_line      = LW'(sl);
        snp_id        = IW'(sid);
        #2;
    endtask

    // Probe: a write shown without grant reveals the state, then is withdrawn (R11)
    task automatic probe(input int l);
        int obs;
        drive(1, 1, l, 0, 0, 0, 0, 0);
        if (cpu_ready && !bus_req_valid) obs = 2;
        else if (bus_req_valid && bus_req_op == 2'd3) obs = 1;
        else if (bus_req_valid && bus_req_op == 2'd2) obs = 0;
        else obs = 7;
        chk(obs == exp_st[l], "R11 line state", obs, exp_st[l]);
    endtask

    task automatic probe_all();
        for (int k = 0; k < N; k++) probe(k);
    endtask

    task automatic cpu_access(input int l, input bit w, input int waits);
        int st;
        bit hit;
        int eop;
        st  = exp_st[l];
        hit = w ? (st == 2) : (st != 0);
        if (hit) begin
            drive(1, w, l, 0, 0, 0, 0, 0);
            chk(cpu_ready && !bus_req_valid, w ? "R5 write hit" : "R3 read hit",
                int'({cpu_ready, bus_req_valid}), 2);
        end else begin
            eop = !w ? 1 : (st == 1 ? 3 : 2);
            for (int i = 0; i < waits; i++) begin
                drive(1, w, l, 0, 0, 0, 0, 0);
                chk(!cpu_ready, "R10 ready while waiting", int'(cpu_ready), 0);
                chk(bus_req_valid && bus_req_op == 2'(eop) && bus_req_line == LW'(l),
                    w ? "R4 request op" : "R2 request op", int'(bus_req_op), eop);
            end
            drive(1, w, l, 1, 1, eop, l, MY);
            chk(cpu_ready && bus_req_op == 2'(eop), w ? "R4 grant" : "R2 grant",
                int'(bus_req_op), eop);
            chk(!flush_valid, "R8 own snoop flush", int'(flush_valid), 0);
            exp_st[l] = w ? 2 : 1;
        end
    endtask

    task automatic snoop(input int l, input int op, input int id);
        bit ef;
        ef = (id != MY) && (exp_st[l] == 2);
        drive(0, 0, 0, 0, 1, op, l, id);
        chk(flush_valid == ef && (!ef || flush_line == LW'(l)),
            id == MY ? "R8 own snoop" : (op == 1 ? "R6 snoop read" : "R7 snoop excl"),
            int'(flush_valid), int'(ef));
        if (id != MY) begin
            if (op == 1 && exp_st[l] == 2) exp_st[l] = 1;
            else if (op >= 2) exp_st[l] = 0;
        end
    endtask

    task automatic set_state(input int l, input int t);
        snoop(l, 2, FOREIGN);
        if (t == 1) cpu_access(l, 0, 0);
        if (t == 2) cpu_access(l, 1, 0);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none

        for (int k = 0; k < N; k++) exp_st[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!cpu_ready && !bus_req_valid && !flush_valid, "R1 idle outputs",
            int'({cpu_ready, bus_req_valid, flush_valid}), 0);
        probe_all();   // R1: all lines Invalid after reset

        // Sweep: every line x every start state x every operation
        for (int l = 0; l < N; l++) begin
            for (int st = 0; st < 3; st++) begin
                for (int op = 0; op < 7; op++) begin
                    set_state(l, st);
                    case (op)
                        0: cpu_access(l, 0, l % 3);
                        1: cpu_access(l, 1, (l + 1) % 3);
                        2: snoop(l, 1, FOREIGN);
                        3: snoop(l, 2, FOREIGN);
                        4: snoop(l, 3, FOREIGN);
                        5: snoop(l, 2, MY);
                        default: begin
                            drive(0, 0, 0, 1, 0, 0, 0, 0);
                            chk(!cpu_ready && !bus_req_valid, "R10 stray grant",
                                int'({cpu_ready, bus_req_valid}), 0);
                        end
                    endcase
                    probe_all();
                end
            end
        end

        // R9: pending upgrade turned into read-exclusive by a foreign invalidation
        set_state(1, 1);
        drive(1, 1, 1, 0, 0, 0, 0, 0);
        chk(bus_req_op == 2'd3, "R4 upgrade op", int'(bus_req_op), 3);
        drive(1, 1, 1, 0, 1, 2, 1, FOREIGN);
        chk(bus_req_op == 2'd2 && !cpu_ready && !flush_valid, "R9 upgrade to rdx",
            int'(bus_req_op), 2);
        exp_st[1] = 0;
        drive(1, 1, 1, 0, 0, 0, 0, 0);
        chk(bus_req_op == 2'd2, "R9 op after snoop", int'(bus_req_op), 2);
        drive(1, 1, 1, 1, 1, 2, 1, MY);
        chk(cpu_ready, "R9 grant", int'(cpu_ready), 1);
        exp_st[1] = 2;
        probe_all();

        // R9: write hit on Modified lost to a same-cycle foreign invalidation
        set_state(2, 2);
        drive(1, 1, 2, 0, 1, 2, 2, FOREIGN);
        chk(flush_valid && flush_line == 2'd2, "R9 flush on same cycle", int'(flush_valid), 1);
        chk(!cpu_ready && bus_req_valid && bus_req_op == 2'd2, "R9 hit becomes miss",
            int'(bus_req_op), 2);
        exp_st[2] = 0;
        probe_all();

        // R9: read hit on Modified with a same-cycle foreign read still hits
        set_state(3, 2);
        drive(1, 0, 3, 0, 1, 1, 3, FOREIGN);
        chk(flush_valid && cpu_ready && !bus_req_valid, "R9 read hit after downgrade",
            int'({flush_valid, cpu_ready, bus_req_valid}), 6);
        exp_st[3] = 1;
        probe_all();

        drive(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule